// File: doc/BRIEF.md
# External Interrupt Flag Register

This block keeps one pending flag for each of six external interrupt request lines and exposes them as one 8-bit status register on a simple read/write bus. Each line is active low and arrives asynchronously. A per-line mode input selects how the line is sensed. In level mode, a low line keeps its flag set. In edge mode, only a high-to-low transition sets the flag.

Software can drop a flag only by writing 0 to it, and only after it has read that flag as 1. Writing 1 never sets anything. The interrupt controller reports which line's exception handling is being carried out through an acknowledge pulse with a line index. That acknowledge clears the flag by itself in edge mode. In level mode it clears the flag only if the line has already returned high. The six flags are also driven out directly as pending outputs for the downstream controller.

Top module: `ext_irq_flags`

## Requirements
- R1: An active-low reset forces every flag to 0 at once, and the register reads 0x00 while reset is held and after it is released.
- R2: Register bits 7 and 6 always read 0. A write of 1 to any bit never sets a flag.
- R3: With `sense_edge[n]`=0, a low level on `irq_n[n]` sets flag n (bit n) after the third rising clock edge. The flag stays set after the line returns high.
- R4: With `sense_edge[n]`=1, only a high-to-low transition of `irq_n[n]` sets flag n. A line held low after its flag was cleared does not set it again, and a low pulse lasting two clock cycles is captured.
- R5: A write of 0 to a flag that was not read as 1 beforehand leaves the flag unchanged.
- R6: A read captures, for each bit, whether it was 1. The next write clears each flag whose bit is written 0 and was read as 1. Every write discards all captured read marks, and a read in the same cycle as a write captures none.
- R7: In level mode, an acknowledge for line n clears flag n only if `irq_n[n]` is high.
- R8: In edge mode, an acknowledge for line n clears flag n even while `irq_n[n]` is low.
- R9: An acknowledge with an index of 6 or 7, or with the index of another line, leaves flag n unchanged.
- R10: When a set condition and a clear condition for a flag fall in the same cycle, the flag ends up set.
- R11: `pending[5:0]` equals register bits 5..0 at all times.
- R12: A read mark is only taken for a bit that is 1 at the time of the read. A flag that sets after a read that saw it 0 survives the following 0-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (also used for standby) |
| rd_en | input | 1 | Register read strobe, one cycle |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data; bit n written 0 requests clear of flag n |
| rd_data | output | 8 | Register contents: flags in bits 5..0, zeros above |
| irq_n | input | 6 | Asynchronous active-low interrupt request lines |
| sense_edge | input | 6 | Per-line mode: 0 level, 1 falling edge |
| ack_valid | input | 1 | One-cycle acknowledge pulse |
| ack_idx | input | 3 | Line whose exception handling is being carried out |
| pending | output | 6 | Flag outputs toward the interrupt controller |

## Verification
Every one of the six lines is swept through the same sequence, first in level mode and then in edge mode. A line held low, a line released high, and a short low pulse separate level sensing from edge sensing. A held-low line that fails to set again after clearing shows that edge detection is not following the level. Clear attempts are made with no preceding read, with a read that saw the bit 0, with a mark already used by an earlier write, and with a valid mark. These separate the read-before-clear rule from a plain 0-write. Acknowledges with the line high, with the line low, with indices 6 and 7, and with a neighbouring index separate the mode-dependent automatic clear from stray clears. A 0-write against a line still held low checks that the set wins.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Set condition for one line: edge mode uses the synchronized falling
  // edge, level mode uses the synchronized low level.
  function automatic logic line_set(input logic edge_mode,
                                    input logic lvl,
                                    input logic fell);
    return edge_mode ? fell : ~lvl;
  endfunction

  // Whether an acknowledge may clear the flag: always in edge mode,
  // only with the line released (high) in level mode.
  function automatic logic ack_may_clear(input logic edge_mode,
                                         input logic lvl);
    return edge_mode | lvl;
  endfunction

  // Next flag value: a set beats any clear.
  function automatic logic flag_next(input logic cur,
                                     input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irq_input_sync.sv
module irq_input_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] fell
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] shr;
    logic              prev;

    // Lines idle high, so the chain resets high and no false edge appears.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shr  <= '1;
        prev <= 1'b1;
      end else begin
        shr  <= {shr[STAGES-2:0], din[g]};
        prev <= shr[LAST];
      end
    end

    assign lvl[g]  = shr[LAST];
    assign fell[g] = prev & ~shr[LAST];
  end

endmodule

// File: rtl/irq_flag_bit.sv
module irq_flag_bit
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic lvl,
  input  logic fell,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic wr_bit,
  input  logic ack_hit,
  output logic flag,
  output logic set_ev,
  output logic sw_clr_ev,
  output logic ack_clr_ev
);

  logic marked;

  assign set_ev     = line_set(edge_mode, lvl, fell);
  assign sw_clr_ev  = wr_strobe & ~wr_bit & marked;
  assign ack_clr_ev = ack_hit & ack_may_clear(edge_mode, lvl);

  // Read mark: remembers that software saw this flag as 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         marked <= 1'b0;
    else if (wr_strobe) marked <= 1'b0;
    else if (rd_strobe) marked <= flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, set_ev, sw_clr_ev | ack_clr_ev);
  end

endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
  parameter int unsigned LINES  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LINES-1:0]  irq_n,
  input  logic [LINES-1:0]  sense_edge,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic [LINES-1:0]  pending
);

  localparam int unsigned PAD = DATA_W - LINES;

  logic [LINES-1:0] lvl;
  logic [LINES-1:0] fell;
  logic [LINES-1:0] flags;
  logic [LINES-1:0] ack_hit;
  logic [LINES-1:0] set_ev;
  logic [LINES-1:0] sw_clr_ev;
  logic [LINES-1:0] ack_clr_ev;
  logic             rd_strobe;

  // A read coinciding with a write takes no marks.
  assign rd_strobe = rd_en & ~wr_en;

  irq_input_sync #(.WIDTH(LINES), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (irq_n),
    .lvl   (lvl),
    .fell  (fell)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_bit
    assign ack_hit[g] = ack_valid && (ack_idx == IDX_W'(g));

    irq_flag_bit u_bit (
      .clk        (clk),
      .rst_n      (rst_n),
      .edge_mode  (sense_edge[g]),
      .lvl        (lvl[g]),
      .fell       (fell[g]),
      .rd_strobe  (rd_strobe),
      .wr_strobe  (wr_en),
      .wr_bit     (wr_data[g]),
      .ack_hit    (ack_hit[g]),
      .flag       (flags[g]),
      .set_ev     (set_ev[g]),
      .sw_clr_ev  (sw_clr_ev[g]),
      .ack_clr_ev (ack_clr_ev[g])
    );
  end

  assign rd_data = {{PAD{1'b0}}, flags};
  assign pending = flags;

endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
  parameter int unsigned LINES  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              ack_valid,
  input logic [IDX_W-1:0]  ack_idx,
  input logic [LINES-1:0]  sense_edge,
  input logic [DATA_W-1:0] rd_data,
  input logic [LINES-1:0]  pending,
  input logic [LINES-1:0]  flags,
  input logic [LINES-1:0]  lvl,
  input logic [LINES-1:0]  set_ev,
  input logic [LINES-1:0]  sw_clr_ev,
  input logic [LINES-1:0]  ack_clr_ev
);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:LINES] == '0);

  a_r11_pend_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    pending == rd_data[LINES-1:0]);

  a_r9_bad_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && (int'(ack_idx) >= LINES)) |-> (ack_clr_ev == '0));

  for (genvar g = 0; g < LINES; g++) begin : g_line
    a_r3_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_edge[g] && !lvl[g]) |=> flags[g]);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[g] |=> flags[g]);

    a_r5_clear_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[g]) |-> $past(wr_en || ack_valid));

    a_r6_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[g]) |-> $past(sw_clr_ev[g] || ack_clr_ev[g]));

    a_r8_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && (int'(ack_idx) == g) && sense_edge[g] && !set_ev[g])
        |=> !flags[g]);
  end

endmodule

bind ext_irq_flags ext_irq_flags_chk #(
  .LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .ack_valid  (ack_valid),
  .ack_idx    (ack_idx),
  .sense_edge (sense_edge),
  .rd_data    (rd_data),
  .pending    (pending),
  .flags      (flags),
  .lvl        (lvl),
  .set_ev     (set_ev),
  .sw_clr_ev  (sw_clr_ev),
  .ack_clr_ev (ack_clr_ev)
);

// File: tb/ext_irq_flags_bench.sv
module ext_irq_flags_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [N-1:0] irq_n = '1;
  logic [N-1:0] sense_edge = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = 3'd0;
  logic [N-1:0] pending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_flags u_ext_irq_flags (
    .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .wr_en (wr_en),
    .wr_data (wr_data), .rd_data (rd_data), .irq_n (irq_n),
    .sense_edge (sense_edge), .ack_valid (ack_valid), .ack_idx (ack_idx),
    .pending (pending)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sample the register plainly (no read strobe) and the pending outputs.
  task automatic look(input string tag, input logic [7:0] exp);
    chk(tag, rd_data, exp);
    chk("R11 pending", {2'b00, pending}, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_rd(output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic do_ack(input logic [2:0] idx);
    @(negedge clk);
    ack_valid = 1'b1;
    ack_idx = idx;
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] bit_i;
    repeat (3) @(negedge clk);
    #1 look("R1 in reset", 8'h00);
    rst_n = 1'b1;
    settle();
    look("R1 after reset", 8'h00);
    do_wr(8'hFF);
    look("R2 write ones sets nothing", 8'h00);

    for (int i = 0; i < N; i++) begin
      bit_i = 8'(1 << i);
      // ---------------- level mode ----------------
      sense_edge = '0;
      irq_n[i] = 1'b0;
      repeat (2) @(negedge clk);
      look("R3 not yet after two edges", 8'h00);
      repeat (2) @(negedge clk);
      look("R3 level low sets", bit_i);
      irq_n[i] = 1'b1;
      settle();
      look("R3 stays after release", bit_i);
      do_wr(8'h00);
      look("R5 zero write without read", bit_i);
      do_rd(r);
      chk("R6 read value", r, bit_i);
      do_wr(8'hFF);
      look("R6 write one keeps flag", bit_i);
      do_wr(8'h00);
      look("R6 mark used by earlier write", bit_i);
      do_ack(3'd6);
      do_ack(3'd7);
      look("R9 index above five", bit_i);
      do_ack(3'((i + 1) % N));
      look("R9 other line index", bit_i);
      do_ack(3'(i));
      look("R7 level ack with line high", 8'h00);
      irq_n[i] = 1'b0;
      settle();
      do_rd(r);
      do_wr(8'h00);
      look("R10 set wins over sw clear", bit_i);
      do_ack(3'(i));
      look("R7 level ack with line low", bit_i);
      irq_n[i] = 1'b1;
      settle();
      do_rd(r);
      do_wr(~bit_i);
      look("R6 marked zero write clears", 8'h00);

      // ---------------- edge mode ----------------
      sense_edge[i] = 1'b1;
      settle();
      look("R4 no set while high", 8'h00);
      irq_n[i] = 1'b0;
      settle();
      look("R4 falling edge sets", bit_i);
      do_rd(r);
      do_wr(8'h00);
      look("R6 edge clear with line low", 8'h00);
      settle();
      look("R4 held low does not reset", 8'h00);
      irq_n[i] = 1'b1;
      settle();
      irq_n[i] = 1'b0;
      repeat (2) @(negedge clk);
      irq_n[i] = 1'b1;
      settle();
      look("R4 short pulse captured", bit_i);
      irq_n[i] = 1'b0;
      settle();
      do_ack(3'(i));
      look("R8 edge ack with line low", 8'h00);
      do_rd(r);
      chk("R12 read sees zero", r, 8'h00);
      irq_n[i] = 1'b1;
      settle();
      irq_n[i] = 1'b0;
      settle();
      do_wr(8'h00);
      look("R12 unmarked flag survives", bit_i);
      do_ack(3'd7);
      look("R9 edge index seven", bit_i);
      do_ack(3'(i));
      look("R8 edge ack clears", 8'h00);
      irq_n[i] = 1'b1;
      settle();
      sense_edge[i] = 1'b0;
      settle();
      look("R3 quiet after mode change", 8'h00);
    end

    // All lines together, then reset in the middle of activity.
    irq_n = '0;
    settle();
    look("R3 all lines low", 8'h3F);
    do_wr(8'hC0);
    look("R2 upper bits stay zero", 8'h3F);
    @(negedge clk);
    rst_n = 1'b0;
    #1 look("R1 async reset clears", 8'h00);
    irq_n = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    look("R1 after release", 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule